// File: doc/BRIEF.md
# I2C Byte-Stepped Master Transmitter

This block is an I2C bus master that only transmits. Software runs it through three write ports: a command port, a data byte and a clock divider. Each command write starts exactly one bus action: a START, a byte (address or data) followed by an acknowledge slot, a repeated START, or a STOP. When the action finishes, the block raises a completion flag and posts an 8-bit status code that says what happened. Software reads the code, loads the next byte if needed, and writes the next command with the flag-clear bit set.

While the flag is high and the block holds the bus, SCL stays low, so the bus waits for software. The data byte may be loaded only while the flag is high. A load attempted at any other time is dropped and a collision bit is raised. Both bus lines are open drain: the block only pulls low and reads back the resolved line levels. It uses that readback to find a free bus before a START and to detect a lost arbitration.

Command byte layout: bit 7 clears the flag, bit 2 asks for STOP, bit 1 asks for START, bit 0 enables the action. Port address 0 is the command, 1 is the data byte, 2 is the divider.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset the flag is low, the status reads 0xF8, the collision bit is low, the data byte is 0x00, and both lines are released.
- R2: A START command (bits 7, 1 and 0 set, bit 2 clear) sent from idle waits until both SCL and SDA read high. It then makes a START, sets the flag and posts status 0x08.
- R3: The flag is cleared only by a command write with bit 7 set. A command write with bit 7 clear leaves the flag and status unchanged and starts no action.
- R4: While the flag is high and the block holds the bus, SCL is driven low.
- R5: A byte command (bits 7 and 0 set, bits 1 and 2 clear) after a START sends the data byte MSB first as the address. It then samples the acknowledge and posts 0x18 for ACK (SDA low) or 0x20 for NACK.
- R6: Any later byte command sends the data byte and posts 0x28 for ACK or 0x30 for NACK.
- R7: A write to the data byte while the flag is low is ignored and sets the collision bit. An accepted write clears the collision bit.
- R8: A START command while the block holds the bus makes a repeated START and posts 0x10.
- R9: A STOP command (bits 7, 2 and 0 set, bit 1 clear) makes a STOP and releases both lines. The flag stays low and the status becomes 0xF8.
- R10: If SDA reads low during an SCL-high phase in which the block released SDA, the block releases both lines, sets the flag and posts 0x38.
- R11: SDA changes while SCL is high only to form a START (falling) or a STOP (rising), so every transmitted byte is seen intact on the bus.
- R12: Each SCL low and high phase of a bit lasts divider+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 command, 1 data byte, 2 divider |
| reg_wdata | input | 8 | Write data |
| irq_flag | output | 1 | Action-complete flag |
| status | output | 8 | Status code of the last action |
| data_q | output | 8 | Current data byte |
| wcol | output | 1 | Write collision bit |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |

## Verification
The assertions check the handshake rules on every cycle: the flag falls only after a command write with bit 7 set, SCL stays low while the flag is up and the bus is held, a data write made while the flag is low is dropped and raises the collision bit, SDA moves during SCL high only for a START or a STOP, and the lines are quiet after a STOP. Only the bench scenarios can show the right status code for each outcome (ACK or NACK on an address or data byte, repeated START, lost arbitration, waiting for a busy bus), the bit order and contents of the bytes on the wire, and the phase length set by the divider.

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
  parameter logic [7:0] DIV_RST = 8'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic       irq_flag,
  output logic [7:0] status,
  output logic [7:0] data_q,
  output logic       wcol,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_drive_low,
  output logic       sda_drive_low
);
  localparam logic [3:0] S_IDLE = 4'd0, S_WFREE = 4'd1, S_STA1 = 4'd2, S_STA2 = 4'd3,
                         S_HOLD = 4'd4, S_BLO = 4'd5, S_BHI = 4'd6, S_ALO = 4'd7,
                         S_AHI = 4'd8, S_STO1 = 4'd9, S_STO2 = 4'd10, S_STO3 = 4'd11,
                         S_RS1 = 4'd12, S_RS2 = 4'd13;

  logic [3:0] state;
  logic [7:0] div_q, cnt, shreg;
  logic [2:0] bitn;
  logic       scl_low, sda_low, owned_q, is_addr, rs_q;

  wire ctl_wr = reg_we && reg_addr == 2'd0;
  wire go     = ctl_wr && reg_wdata[7] && reg_wdata[0];
  wire timed  = state inside {S_STA1, S_STA2, S_BLO, S_BHI, S_ALO, S_AHI,
                              S_STO1, S_STO2, S_STO3, S_RS1, S_RS2};
  wire tick   = cnt == div_q;

  assign scl_drive_low = scl_low;
  assign sda_drive_low = sda_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; div_q <= DIV_RST; cnt <= '0; shreg <= '0; bitn <= '0;
      scl_low <= 1'b0; sda_low <= 1'b0; owned_q <= 1'b0; is_addr <= 1'b0; rs_q <= 1'b0;
      irq_flag <= 1'b0; status <= 8'hF8; data_q <= '0; wcol <= 1'b0;
    end else begin
      cnt <= (timed && !tick) ? cnt + 8'd1 : 8'd0;
      if (reg_we && reg_addr == 2'd2) div_q <= reg_wdata;
      if (reg_we && reg_addr == 2'd1) begin
        if (irq_flag) begin data_q <= reg_wdata; wcol <= 1'b0; end
        else wcol <= 1'b1;
      end
      if (ctl_wr && reg_wdata[7]) irq_flag <= 1'b0;

      case (state)
        S_IDLE: if (go && reg_wdata[1] && !reg_wdata[2]) state <= S_WFREE;
        S_WFREE: if (scl_i && sda_i) begin
          sda_low <= 1'b1; rs_q <= 1'b0; state <= S_STA1;
        end
        S_STA1: if (tick) begin scl_low <= 1'b1; state <= S_STA2; end
        S_STA2: if (tick) begin
          irq_flag <= 1'b1; status <= rs_q ? 8'h10 : 8'h08;
          owned_q <= 1'b1; is_addr <= 1'b1; state <= S_HOLD;
        end
        S_HOLD: if (go) begin
          if (reg_wdata[2]) begin sda_low <= 1'b1; state <= S_STO1; end
          else if (reg_wdata[1]) begin sda_low <= 1'b0; state <= S_RS1; end
          else begin
            shreg <= data_q; bitn <= 3'd7; sda_low <= ~data_q[7]; state <= S_BLO;
          end
        end
        S_BLO: if (tick) begin scl_low <= 1'b0; state <= S_BHI; end
        S_BHI: if (tick) begin
          if (!sda_low && !sda_i) begin
            status <= 8'h38; irq_flag <= 1'b1; owned_q <= 1'b0;
            scl_low <= 1'b0; sda_low <= 1'b0; state <= S_IDLE;
          end else begin
            scl_low <= 1'b1;
            if (bitn == 3'd0) begin sda_low <= 1'b0; state <= S_ALO; end
            else begin
              bitn <= bitn - 3'd1; shreg <= {shreg[6:0], 1'b0};
              sda_low <= ~shreg[6]; state <= S_BLO;
            end
          end
        end
        S_ALO: if (tick) begin scl_low <= 1'b0; state <= S_AHI; end
        S_AHI: if (tick) begin
          scl_low <= 1'b1; irq_flag <= 1'b1; is_addr <= 1'b0;
          if (is_addr) status <= sda_i ? 8'h20 : 8'h18;
          else         status <= sda_i ? 8'h30 : 8'h28;
          state <= S_HOLD;
        end
        S_STO1: if (tick) begin scl_low <= 1'b0; state <= S_STO2; end
        S_STO2: if (tick) begin sda_low <= 1'b0; state <= S_STO3; end
        S_STO3: if (tick) begin owned_q <= 1'b0; status <= 8'hF8; state <= S_IDLE; end
        S_RS1: if (tick) begin scl_low <= 1'b0; state <= S_RS2; end
        S_RS2: if (tick) begin sda_low <= 1'b1; rs_q <= 1'b1; state <= S_STA1; end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module i2c_tx_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       irq_flag,
  input logic       wcol,
  input logic [7:0] data_q,
  input logic       scl_drive_low,
  input logic       sda_drive_low,
  input logic       owned,
  input logic [3:0] st
);
  AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(reg_we && reg_addr == 2'd0 && reg_wdata[7])); // R3
  AST_STALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && owned) |-> scl_drive_low); // R4
  AST_COLLISION_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1 && !irq_flag) |=> (wcol && $stable(data_q))); // R7
  AST_SDA_ONLY_START_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(sda_drive_low) && !scl_drive_low && $past(!scl_drive_low))
      |-> (sda_drive_low ? st == 4'd2 : st == 4'd11)); // R11
  AST_QUIET_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0 && $past(st) == 4'd11) |-> (!irq_flag && !scl_drive_low && !sda_drive_low)); // R9
endmodule

bind i2c_tx_master i2c_tx_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_flag(irq_flag), .wcol(wcol), .data_q(data_q), .scl_drive_low(scl_drive_low),
  .sda_drive_low(sda_drive_low), .owned(owned_q), .st(state)
);

// File: tb/i2c_tx_master_tb.sv
module i2c_tx_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic irq_flag, wcol, scl_dl, sda_dl;
  logic [7:0] status, data_q;
  logic s_ack = 1'b0, ack_en = 1'b1, force_low = 1'b0;
  logic scl, sda;
  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  int hi_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl = !scl_dl;
  assign sda = !(sda_dl || s_ack || force_low);

  i2c_tx_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .irq_flag(irq_flag), .status(status), .data_q(data_q), .wcol(wcol),
    .scl_i(scl), .sda_i(sda), .scl_drive_low(scl_dl), .sda_drive_low(sda_dl)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (irq_flag) break;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (status == 8'hF8) break;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic push);
    wr(2'd1, b);
    if (push) exp_q.push_back(b);
    wr(2'd0, 8'h81);
    wait_flag();
  endtask

  // bus monitor: slave model and scoreboard
  logic p_scl = 1'b1, p_sda = 1'b1;
  int bitc = 0, hi = 0;
  logic [7:0] rx = '0;
  always @(negedge clk) begin
    if (scl && p_scl && p_sda && !sda) bitc = 0;
    if (scl && !p_scl) begin
      if (bitc < 8) begin
        rx = {rx[6:0], sda};
        bitc++;
        if (bitc == 8) begin
          tests++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R11 unexpected byte actual=%h expected=none", rx);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (rx !== e) begin
              fails++;
              $display("FAIL R11 byte on bus actual=%h expected=%h", rx, e);
            end
          end
        end
      end else bitc = 0;
    end
    if (!scl && p_scl) begin
      hi_len = hi;
      s_ack = (bitc == 8) && ack_en;
    end
    hi = scl ? hi + 1 : 0;
    p_scl = scl; p_sda = sda;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flag", {7'd0, irq_flag}, 8'h00);
    chk("R1 status", status, 8'hF8);
    chk("R1 wcol", {7'd0, wcol}, 8'h00);
    chk("R1 lines", {6'd0, scl_dl, sda_dl}, 8'h00);
    chk("R1 data", data_q, 8'h00);
    wr(2'd2, 8'd2);
    // R7 collision while flag low
    wr(2'd1, 8'h55);
    chk("R7 wcol set", {7'd0, wcol}, 8'h01);
    chk("R7 data kept", data_q, 8'h00);
    // R2 waits for free bus
    force_low = 1'b1;
    wr(2'd0, 8'h83);
    repeat (20) @(negedge clk);
    chk("R2 no start while busy", {6'd0, irq_flag, sda_dl}, 8'h00);
    force_low = 1'b0;
    wait_flag();
    chk("R2 start flag", {7'd0, irq_flag}, 8'h01);
    chk("R2 start status", status, 8'h08);
    // R4 stall
    repeat (10) @(negedge clk);
    chk("R4 scl held low", {6'd0, irq_flag, scl_dl}, 8'h03);
    // R3 write without bit 7
    wr(2'd0, 8'h01);
    repeat (10) @(negedge clk);
    chk("R3 flag kept", {7'd0, irq_flag}, 8'h01);
    chk("R3 status kept", status, 8'h08);
    // R5 address ACK
    ack_en = 1'b1;
    wr(2'd1, 8'hA0);
    chk("R7 wcol cleared", {7'd0, wcol}, 8'h00);
    chk("R7 data loaded", data_q, 8'hA0);
    exp_q.push_back(8'hA0);
    wr(2'd0, 8'h81);
    wait_flag();
    chk("R5 addr ack", status, 8'h18);
    chk("R12 high phase", hi_len[7:0], 8'd3);
    // R6 data ACK and NACK
    send_byte(8'h3C, 1'b1);
    chk("R6 data ack", status, 8'h28);
    ack_en = 1'b0;
    send_byte(8'hC5, 1'b1);
    chk("R6 data nack", status, 8'h30);
    // R8 repeated start
    wr(2'd0, 8'h83);
    wait_flag();
    chk("R8 rep start", status, 8'h10);
    send_byte(8'h91, 1'b1);
    chk("R5 addr nack", status, 8'h20);
    // R9 stop
    wr(2'd0, 8'h85);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R9 status", status, 8'hF8);
    chk("R9 flag low", {7'd0, irq_flag}, 8'h00);
    chk("R9 lines", {6'd0, scl_dl, sda_dl}, 8'h00);
    // R10 arbitration lost
    ack_en = 1'b1;
    wr(2'd0, 8'h83);
    wait_flag();
    chk("R2 second start", status, 8'h08);
    wr(2'd1, 8'hA0);
    force_low = 1'b1;
    wr(2'd0, 8'h81);
    wait_flag();
    chk("R10 status", status, 8'h38);
    chk("R10 lines", {6'd0, scl_dl, sda_dl}, 8'h00);
    force_low = 1'b0;
    repeat (5) @(negedge clk);
    // recover with a fresh transfer
    wr(2'd0, 8'h83);
    wait_flag();
    chk("R2 start after loss", status, 8'h08);
    send_byte(8'h6B, 1'b1);
    chk("R5 addr ack again", status, 8'h18);
    wr(2'd0, 8'h85);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R9 final status", status, 8'hF8);
    chk("R11 queue drained", 8'(exp_q.size()), 8'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule